// File: doc/BRIEF.md
# Write-Only Two-Wire Configuration Receiver

This block is a write-only slave on a two-wire serial bus. It holds four 8-bit control registers for a clock generator. The clock and data lines are oversampled by a system clock that runs at least eight times faster than the serial clock. The block finds START and STOP conditions, shifts in bytes, pulls the data line low to acknowledge each byte, and commits the incoming data to its registers one byte at a time.

Every write uses a frame of exactly ten bytes. The first byte is the device address. It is followed by two protocol bytes and then seven data bytes. The block checks only the address. The two protocol bytes and the first three data bytes are received and counted so that byte positions stay aligned, and then they are dropped. The last four data bytes load registers 0 to 3 in order. The registers come up with fixed defaults, so writing them is optional. A frame that ends early, or is cut off by a new START, raises a frame-error flag. Bytes already committed are kept.

Top module: `cfg_serial_rx`

## Requirements
- R1: After reset, register 0 holds 8'h00, register 1 holds 8'h23, register 2 holds 8'h EF, register 3 holds 8'h45. The strobe, ack-drive and frame-error outputs are all low.
- R2: When the first byte after a START equals 8'b11010010, the block asserts `ack_drive_o` during the ninth serial clock of each of the ten frame bytes.
- R3: When the address byte does not match, no byte is acknowledged and no register or strobe changes until the next START.
- R4: In a matched frame, bytes 7, 8, 9 and 10 (counting from 1) load registers 0, 1, 2 and 3. Bytes 2 to 6 have no effect on any register.
- R5: Each byte is taken most significant bit first, sampled on rising edges of the serial clock.
- R6: Each register update comes with a one-cycle pulse on bit k of `wr_strobe_o`, where k is the index of the updated register, in the same cycle that the new value appears. At most one strobe bit is high at a time, and a strobe only occurs while `ack_drive_o` is high.
- R7: A STOP received after the address has been acknowledged but before the tenth byte completes sets `frame_err_o`. Registers committed earlier in that frame keep their new values, and the others keep their old values.
- R8: A frame with all ten bytes followed by STOP leaves `frame_err_o` low. Bytes sent after the tenth are not acknowledged and change nothing.
- R9: A START inside an acknowledged, incomplete frame sets `frame_err_o` and begins a new frame at the address byte. A START outside a frame clears `frame_err_o`.
- R10: Register contents are stored exactly as written, including bits the clock generator treats as reserved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, at least 8x the serial clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line, asynchronous |
| sda_i | input | 1 | Serial data line as seen on the bus, asynchronous |
| ack_drive_o | output | 1 | 1 = pull the data line low for acknowledge |
| cfg_reg0_o | output | 8 | Control register 0 (frame byte 7) |
| cfg_reg1_o | output | 8 | Control register 1 (frame byte 8) |
| cfg_reg2_o | output | 8 | Control register 2 (frame byte 9) |
| cfg_reg3_o | output | 8 | Control register 3 (frame byte 10) |
| wr_strobe_o | output | 4 | One-cycle pulse per updated register |
| frame_err_o | output | 1 | Frame ended or restarted before byte 10 |

## Verification
Both the register commit and the start of the acknowledge come from the same serial-clock falling edge that closes the eighth bit. As a result, a strobe always lands while the acknowledge is being driven. The bench sends frames whose data bytes are written to registers, watches every cycle in which a strobe fires, and counts a failure if the acknowledge is not asserted in that cycle or if more than one strobe bit is high. A second overlap happens when a new START arrives in the middle of a frame: the frame is aborted, the error flag is raised and reception restarts, all on one edge. The bench provokes this with a repeated START after three acknowledged bytes. It then checks the error flag and the registers loaded by the frame that follows.

// File: rtl/cfgrx_pkg.sv
package cfgrx_pkg;
    localparam int BYTE_W        = 8;
    localparam int NUM_REGS      = 4;
    localparam int FRAME_LEN     = 10;
    localparam int FIRST_REG_POS = FRAME_LEN - NUM_REGS;
    localparam int SYNC_STAGES   = 2;
    localparam logic [BYTE_W-1:0] DEV_ADDR = 8'b1101_0010;
    localparam logic [NUM_REGS*BYTE_W-1:0] REG_DEFAULTS = {8'h45, 8'hEF, 8'h23, 8'h00};

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_ACK,
        ST_SKIP
    } rx_state_e;
endpackage

// File: rtl/cfgrx_line_mon.sv
module cfgrx_line_mon #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic sda_o,
    output logic start_o,
    output logic stop_o
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl_sync;
        logic [SYNC_STAGES-1:0] sda_sync;
        logic                   scl_prev;
        logic                   sda_prev;
    } mon_t;

    mon_t mon_d, mon_q;
    logic scl_now, sda_now;

    assign scl_now = mon_q.scl_sync[SYNC_STAGES-1];
    assign sda_now = mon_q.sda_sync[SYNC_STAGES-1];

    always_comb begin
        mon_d          = mon_q;
        mon_d.scl_sync = {mon_q.scl_sync[SYNC_STAGES-2:0], scl_i};
        mon_d.sda_sync = {mon_q.sda_sync[SYNC_STAGES-2:0], sda_i};
        mon_d.scl_prev = scl_now;
        mon_d.sda_prev = sda_now;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mon_q <= '1;
        end else begin
            mon_q <= mon_d;
        end
    end

    // edges and bus conditions from the synchronised pair
    assign scl_rise_o = scl_now & ~mon_q.scl_prev;
    assign scl_fall_o = ~scl_now & mon_q.scl_prev;
    assign sda_o      = sda_now;
    assign start_o    = scl_now & mon_q.scl_prev & mon_q.sda_prev & ~sda_now;
    assign stop_o     = scl_now & mon_q.scl_prev & ~mon_q.sda_prev & sda_now;
endmodule

// File: rtl/cfgrx_frame_fsm.sv
module cfgrx_frame_fsm
    import cfgrx_pkg::*;
#(
    parameter int BYTE_W_P   = 8,
    parameter int FRAME_LEN_P = 10,
    parameter int NUM_REGS_P = 4,
    parameter logic [BYTE_W_P-1:0] ADDR_P = 8'hD2,
    localparam int FIRST_P = FRAME_LEN_P - NUM_REGS_P,
    localparam int IDX_W   = $clog2(FRAME_LEN_P + 1),
    localparam int BIT_W   = $clog2(BYTE_W_P + 1),
    localparam int SEL_W   = (NUM_REGS_P > 1) ? $clog2(NUM_REGS_P) : 1
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                scl_rise_i,
    input  logic                scl_fall_i,
    input  logic                sda_i,
    input  logic                start_i,
    input  logic                stop_i,
    output logic                ack_o,
    output logic                wr_en_o,
    output logic [SEL_W-1:0]    wr_sel_o,
    output logic [BYTE_W_P-1:0] wr_data_o,
    output logic                frame_err_o
);
    typedef struct packed {
        rx_state_e           state;
        logic [BIT_W-1:0]    bit_cnt;
        logic [IDX_W-1:0]    byte_idx;
        logic [BYTE_W_P-1:0] shreg;
        logic                ack;
        logic                err;
        logic                wr_en;
        logic [SEL_W-1:0]    wr_sel;
        logic [BYTE_W_P-1:0] wr_data;
    } fsm_t;

    fsm_t fsm_d, fsm_q;
    logic in_frame;

    // acknowledged address, frame not yet finished
    assign in_frame = (fsm_q.state == ST_ACK) ||
                      ((fsm_q.state == ST_SHIFT) && (fsm_q.byte_idx != '0));

    always_comb begin
        fsm_d       = fsm_q;
        fsm_d.wr_en = 1'b0;
        if (start_i) begin
            fsm_d.state    = ST_SHIFT;
            fsm_d.bit_cnt  = '0;
            fsm_d.byte_idx = '0;
            fsm_d.shreg    = '0;
            fsm_d.ack      = 1'b0;
            fsm_d.err      = in_frame;
        end else if (stop_i) begin
            fsm_d.state   = ST_IDLE;
            fsm_d.bit_cnt = '0;
            fsm_d.ack     = 1'b0;
            if (in_frame) begin
                fsm_d.err = 1'b1;
            end
        end else begin
            unique case (fsm_q.state)
                ST_SHIFT: begin
                    if (scl_rise_i && (fsm_q.bit_cnt < BIT_W'(BYTE_W_P))) begin
                        fsm_d.shreg   = {fsm_q.shreg[BYTE_W_P-2:0], sda_i};
                        fsm_d.bit_cnt = fsm_q.bit_cnt + BIT_W'(1);
                    end else if (scl_fall_i && (fsm_q.bit_cnt == BIT_W'(BYTE_W_P))) begin
                        if ((fsm_q.byte_idx == '0) && (fsm_q.shreg != ADDR_P)) begin
                            fsm_d.state = ST_SKIP;
                        end else begin
                            fsm_d.state = ST_ACK;
                            fsm_d.ack   = 1'b1;
                            if (fsm_q.byte_idx >= IDX_W'(FIRST_P)) begin
                                fsm_d.wr_en   = 1'b1;
                                fsm_d.wr_sel  = SEL_W'(fsm_q.byte_idx - IDX_W'(FIRST_P));
                                fsm_d.wr_data = fsm_q.shreg;
                            end
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall_i) begin
                        fsm_d.ack     = 1'b0;
                        fsm_d.bit_cnt = '0;
                        if (fsm_q.byte_idx == IDX_W'(FRAME_LEN_P - 1)) begin
                            fsm_d.state = ST_SKIP;
                        end else begin
                            fsm_d.state    = ST_SHIFT;
                            fsm_d.byte_idx = fsm_q.byte_idx + IDX_W'(1);
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            fsm_q <= '{state: ST_IDLE, default: '0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign ack_o       = fsm_q.ack;
    assign wr_en_o     = fsm_q.wr_en;
    assign wr_sel_o    = fsm_q.wr_sel;
    assign wr_data_o   = fsm_q.wr_data;
    assign frame_err_o = fsm_q.err;
endmodule

// File: rtl/cfgrx_reg_bank.sv
module cfgrx_reg_bank #(
    parameter int WIDTH = 8,
    parameter int NUM   = 4,
    parameter logic [NUM*WIDTH-1:0] RESET_VAL = '0,
    localparam int SEL_W = (NUM > 1) ? $clog2(NUM) : 1
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 wr_en_i,
    input  logic [SEL_W-1:0]     wr_sel_i,
    input  logic [WIDTH-1:0]     wr_data_i,
    output logic [NUM*WIDTH-1:0] regs_o,
    output logic [NUM-1:0]       strobe_o
);
    typedef struct packed {
        logic [NUM*WIDTH-1:0] regs;
        logic [NUM-1:0]       stb;
    } bank_t;

    bank_t bank_d, bank_q;
    logic [NUM-1:0] hit;

    for (genvar k = 0; k < NUM; k++) begin : g_decode
        assign hit[k] = wr_en_i && (wr_sel_i == SEL_W'(k));
    end

    always_comb begin
        bank_d     = bank_q;
        bank_d.stb = hit;
        for (int k = 0; k < NUM; k++) begin
            if (hit[k]) begin
                bank_d.regs[k*WIDTH +: WIDTH] = wr_data_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            bank_q <= '{regs: RESET_VAL, stb: '0};
        end else begin
            bank_q <= bank_d;
        end
    end

    assign regs_o   = bank_q.regs;
    assign strobe_o = bank_q.stb;
endmodule

// File: rtl/cfg_serial_rx.sv
module cfg_serial_rx
    import cfgrx_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                scl_i,
    input  logic                sda_i,
    output logic                ack_drive_o,
    output logic [BYTE_W-1:0]   cfg_reg0_o,
    output logic [BYTE_W-1:0]   cfg_reg1_o,
    output logic [BYTE_W-1:0]   cfg_reg2_o,
    output logic [BYTE_W-1:0]   cfg_reg3_o,
    output logic [NUM_REGS-1:0] wr_strobe_o,
    output logic                frame_err_o
);
    localparam int SEL_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic scl_rise, scl_fall, sda_bit, start_det, stop_det;
    logic wr_en;
    logic [SEL_W-1:0] wr_sel;
    logic [BYTE_W-1:0] wr_data;
    logic [NUM_REGS*BYTE_W-1:0] regs;

    cfgrx_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_line_mon (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .sda_o      (sda_bit),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    cfgrx_frame_fsm #(
        .BYTE_W_P    (BYTE_W),
        .FRAME_LEN_P (FRAME_LEN),
        .NUM_REGS_P  (NUM_REGS),
        .ADDR_P      (DEV_ADDR)
    ) u_frame_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .scl_rise_i  (scl_rise),
        .scl_fall_i  (scl_fall),
        .sda_i       (sda_bit),
        .start_i     (start_det),
        .stop_i      (stop_det),
        .ack_o       (ack_drive_o),
        .wr_en_o     (wr_en),
        .wr_sel_o    (wr_sel),
        .wr_data_o   (wr_data),
        .frame_err_o (frame_err_o)
    );

    cfgrx_reg_bank #(
        .WIDTH     (BYTE_W),
        .NUM       (NUM_REGS),
        .RESET_VAL (REG_DEFAULTS)
    ) u_reg_bank (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en),
        .wr_sel_i  (wr_sel),
        .wr_data_i (wr_data),
        .regs_o    (regs),
        .strobe_o  (wr_strobe_o)
    );

    assign cfg_reg0_o = regs[0*BYTE_W +: BYTE_W];
    assign cfg_reg1_o = regs[1*BYTE_W +: BYTE_W];
    assign cfg_reg2_o = regs[2*BYTE_W +: BYTE_W];
    assign cfg_reg3_o = regs[3*BYTE_W +: BYTE_W];
endmodule

// File: rtl/cfg_serial_rx_chk.sv
module cfg_serial_rx_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       scl_i,
    input logic       sda_i,
    input logic       ack_drive_o,
    input logic [7:0] cfg_reg0_o,
    input logic [7:0] cfg_reg1_o,
    input logic [7:0] cfg_reg2_o,
    input logic [7:0] cfg_reg3_o,
    input logic [3:0] wr_strobe_o,
    input logic       frame_err_o
);
    AST_STROBE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(wr_strobe_o)); // R6
    AST_STROBE_UNDER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_strobe_o != 4'b0) |-> ack_drive_o); // R6
    AST_REG0_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_strobe_o[0] |-> $stable(cfg_reg0_o)); // R4
    AST_REG1_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_strobe_o[1] |-> $stable(cfg_reg1_o)); // R4
    AST_REG2_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_strobe_o[2] |-> $stable(cfg_reg2_o)); // R4
    AST_REG3_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_strobe_o[3] |-> $stable(cfg_reg3_o)); // R4
    AST_ACK_WHILE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ack_drive_o) |-> !scl_i); // R2
    AST_ERR_NOT_DURING_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(frame_err_o) |-> !ack_drive_o); // R7
endmodule

bind cfg_serial_rx cfg_serial_rx_chk u_chk (.*);

// File: tb/cfg_serial_rx_bench.sv
module cfg_serial_rx_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_line;
    logic ack_drive;
    logic [7:0] r0, r1, r2, r3;
    logic [3:0] stb;
    logic ferr;

    int n_chk = 0;
    int n_bad = 0;
    int stb_cnt = 0;
    bit finished = 1'b0;
    logic [7:0] mdl [4];

    always #2.5 clk = ~clk;
    assign sda_line = sda_m & ~ack_drive;

    cfg_serial_rx u_cfg_serial_rx (
        .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
        .ack_drive_o(ack_drive), .cfg_reg0_o(r0), .cfg_reg1_o(r1),
        .cfg_reg2_o(r2), .cfg_reg3_o(r3), .wr_strobe_o(stb), .frame_err_o(ferr)
    );

    // {address, reg0..reg3 data, bytes sent}
    localparam logic [43:0] VEC [8] = '{
        {8'hD2, 32'h11223344, 4'd10},
        {8'hD3, 32'hFFFFFFFF, 4'd10},
        {8'hD2, 32'h80017EC3, 4'd8},
        {8'hD2, 32'h5AA50FF0, 4'd11},
        {8'h52, 32'h99999999, 4'd10},
        {8'hD2, 32'h00000000, 4'd1},
        {8'hD2, 32'hFFFEFDFC, 4'd6},
        {8'hD2, 32'h12345678, 4'd9}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // strobe monitor, R6: one-hot and only under acknowledge
    always @(negedge clk) begin
        if (rst_n && (stb != 4'b0)) begin
            stb_cnt += $countones(stb);
            check("R6 strobe one-hot", 32'($countones(stb)), 32'd1);
            check("R6 strobe with ack", 32'(ack_drive), 32'd1);
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        wait_clk(4); sda_m = 1'b1;
        wait_clk(4); scl = 1'b1;
        wait_clk(8); sda_m = 1'b0;
        wait_clk(8); scl = 1'b0;
    endtask

    task automatic bus_stop();
        wait_clk(4); sda_m = 1'b0;
        wait_clk(4); scl = 1'b1;
        wait_clk(8); sda_m = 1'b1;
        wait_clk(8);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            wait_clk(4); sda_m = b[i];
            wait_clk(4); scl = 1'b1;
            wait_clk(8); scl = 1'b0;
        end
        wait_clk(4); sda_m = 1'b1;
        wait_clk(4); scl = 1'b1;
        wait_clk(4); acked = ~sda_line;
        wait_clk(4); scl = 1'b0;
    endtask

    function automatic logic [7:0] frame_byte(input logic [7:0] addr, input logic [31:0] data, input int pos);
        if (pos == 1) return addr;
        if (pos >= 7 && pos <= 10) return data[31 - 8*(pos-7) -: 8];
        return 8'(8'hC3 ^ pos);
    endfunction

    task automatic check_regs(input string req);
        check(req, 32'(r0), 32'(mdl[0]));
        check(req, 32'(r1), 32'(mdl[1]));
        check(req, 32'(r2), 32'(mdl[2]));
        check(req, 32'(r3), 32'(mdl[3]));
    endtask

    task automatic run_frame(input logic [7:0] addr, input logic [31:0] data, input int nb);
        int acks;
        logic a;
        bit match;
        int reach;
        acks = 0;
        stb_cnt = 0;
        match = (addr == 8'hD2);
        bus_start();
        for (int j = 1; j <= nb; j++) begin
            send_byte(frame_byte(addr, data, j), a);
            acks += int'(a);
        end
        bus_stop();
        wait_clk(10);
        reach = (nb > 10) ? 10 : nb;
        if (match) begin
            for (int k = 0; k < 4; k++) begin
                if (reach >= 7 + k) mdl[k] = data[31 - 8*k -: 8];
            end
        end
        check(match ? "R2 ack count" : "R3 no ack", 32'(acks), match ? 32'(reach) : 32'd0);
        check_regs(match ? "R4 R5 R10 register contents" : "R3 registers untouched");
        check("R7 R8 frame error", 32'(ferr), 32'(match && nb < 10));
        check("R6 strobe count", 32'(stb_cnt), (match && reach > 6) ? 32'(reach - 6) : 32'd0);
    endtask

    initial begin
        logic a;
        mdl[0] = 8'h00; mdl[1] = 8'h23; mdl[2] = 8'hEF; mdl[3] = 8'h45;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        // R1 reset values
        check_regs("R1 reset registers");
        check("R1 reset strobe", 32'(stb), 32'd0);
        check("R1 reset error", 32'(ferr), 32'd0);
        check("R1 reset ack", 32'(ack_drive), 32'd0);

        for (int v = 0; v < 8; v++) begin
            run_frame(VEC[v][43:36], VEC[v][35:4], int'(VEC[v][3:0]));
        end

        // R9 repeated START inside a frame, then a complete frame
        bus_start();
        for (int j = 1; j <= 3; j++) send_byte(frame_byte(8'hD2, 32'h0, j), a);
        bus_start();
        check("R9 error on mid-frame START", 32'(ferr), 32'd1);
        for (int j = 1; j <= 10; j++) send_byte(frame_byte(8'hD2, 32'hA1B2C3D4, j), a);
        bus_stop();
        wait_clk(10);
        mdl[0] = 8'hA1; mdl[1] = 8'hB2; mdl[2] = 8'hC3; mdl[3] = 8'hD4;
        check_regs("R9 frame after restart");
        check("R9 error held", 32'(ferr), 32'd1);

        // R9 clear at fresh START; R3 wrong address leaves registers
        run_frame(8'hD0, 32'h01020304, 10);
        check("R9 error cleared", 32'(ferr), 32'd0);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule